// File: doc/BRIEF.md
# Clear-on-Compare Square Wave Timer

This block makes a square wave from the system clock. A selectable prescaler divides the clock into ticks. A 16-bit up-counter advances once per tick. When the counter reaches the active compare value, the next tick returns it to zero instead of letting it run on to its maximum. That same event, a compare match, inverts the output pin. The pin therefore completes one full period every 2*(1+compare) ticks, so the output frequency is clock/(2*ratio*(1+compare)). For example, a compare value of 2272 with the divide-by-8 ratio at a 16 MHz clock gives close to 440 Hz.

Software-style control comes through four inputs. A 3-bit divider code picks the ratio or stops the timer. A compare value with a load strobe sets the count limit. An enable connects or disconnects the pin. A match flag pulses once for every compare event, so a neighbouring block can count half-periods. While the timer runs, a new compare value waits in a shadow register until the next clear. This keeps the counter from running past a lowered limit. While the timer is stopped, a load takes effect at once.

Top module: `ctc_wave_timer`

## Requirements
- R1: The divider code sets the tick ratio: 1 gives /1, 2 gives /8, 3 gives /64, 4 gives /256 and 5 gives /1024. Starting from reset, the pin first changes ratio*(C+1) clocks after the code is applied, and then keeps changing every ratio*(C+1) clocks, where C is the compare value.
- R2: Codes 0, 6 and 7 stop the timer. The counter, the pin and the match flag hold, and the prescaler count returns to 0.
- R3: On a tick at which the count equals the active compare value, the counter becomes 0. Each half-period therefore lasts C+1 ticks, and a compare value of 0 gives a half-period of one tick.
- R4: A load while the timer runs is held and becomes active at the next clear. The half-period in progress keeps the old value, and the count never exceeds the active compare value.
- R5: A load while the timer is stopped makes the value active at once and sets the counter to 0.
- R6: With the enable high, every compare match inverts the pin. With the enable low, the counter keeps running and the pin holds its level.
- R7: The match flag is high for one clock after each compare match, whether the enable is high or low.
- R8: Reset sets the pin, the match flag, the counter, the prescaler count and the active compare value to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 3 | Divider code (0, 6, 7 stop; 1..5 select /1, /8, /64, /256, /1024) |
| cmp_val | input | 16 | Compare value |
| cmp_load | input | 1 | Strobe that loads cmp_val |
| pin_en | input | 1 | Connects the match toggle to the pin |
| wave_o | output | 1 | Square-wave output |
| match_o | output | 1 | One-clock pulse per compare match |

## Verification
The bench builds the block with its default 16-bit counter and 3-bit divider code. At that size every ratio can be reached: a half-period up to 1024 clocks at the largest divider, and the 440 Hz example with compare 2272 at /8. Directed cases cover a compare value lowered in mid-count, stopped codes 6 and 0, and a disconnected pin that still reports matches.

// File: rtl/ctcw_pkg.sv
package ctcw_pkg;
  localparam int SEL_W = 3;
  localparam int PRE_W = 10;

  // Divide ratio for a divider code, 0 when the code stops the timer.
  function automatic int unsigned ctcw_ratio(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    return 1;
      3'd2:    return 8;
      3'd3:    return 64;
      3'd4:    return 256;
      3'd5:    return 1024;
      default: return 0;
    endcase
  endfunction

  // Clocks in one output half-period.
  function automatic int unsigned ctcw_half_clocks(input int unsigned ratio,
                                                   input int unsigned cmp);
    return ratio * (cmp + 1);
  endfunction
endpackage

// File: rtl/ctcw_prescaler.sv
module ctcw_prescaler
  import ctcw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             run_o,
  output logic             tick_o
);
  int unsigned       ratio;
  logic [PRE_W-1:0]  last_cnt;
  logic [PRE_W-1:0]  pcnt;

  always_comb begin
    ratio    = ctcw_ratio(sel_i);
    run_o    = (ratio != 0);
    last_cnt = run_o ? PRE_W'(ratio - 1) : '0;
    tick_o   = run_o && (pcnt >= last_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (!run_o) pcnt <= '0;
    else if (tick_o) pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end

  AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> pcnt == '0); // R1
  AST_STOP_CLEARS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |=> pcnt == '0); // R2
endmodule

// File: rtl/ctcw_counter.sv
module ctcw_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             cmp_load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] act_cmp;
  logic [CNT_W-1:0] shadow_cmp;
  logic             pend;

  assign hit_o = tick_i && (cnt_o == act_cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o      <= '0;
      act_cmp    <= '0;
      shadow_cmp <= '0;
      pend       <= 1'b0;
    end else if (!run_i && cmp_load_i) begin
      act_cmp <= cmp_val_i;
      cnt_o   <= '0;
      pend    <= 1'b0;
    end else if (hit_o) begin
      cnt_o <= '0;
      if (cmp_load_i) begin
        act_cmp <= cmp_val_i;
        pend    <= 1'b0;
      end else if (pend) begin
        act_cmp <= shadow_cmp;
        pend    <= 1'b0;
      end
    end else begin
      if (cmp_load_i) begin
        shadow_cmp <= cmp_val_i;
        pend       <= 1'b1;
      end
      if (tick_i) cnt_o <= cnt_o + 1'b1;
    end
  end

  AST_CLEAR_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> cnt_o == '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= act_cmp); // R4
  AST_LIMIT_AT_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_o && !(cmp_load_i && !run_i)) |=> $stable(act_cmp)); // R4
  AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && cmp_load_i) |=> (cnt_o == '0 && act_cmp == $past(cmp_val_i))); // R5
endmodule

// File: rtl/ctcw_toggle.sv
module ctcw_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic en_i,
  output logic wave_o,
  output logic match_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      match_o <= hit_i;
      if (hit_i && en_i) wave_o <= ~wave_o;
    end
  end

  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && en_i) |=> wave_o != $past(wave_o)); // R6
  AST_PIN_HOLDS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(wave_o)); // R6
  AST_FLAG_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> match_o); // R7
endmodule

// File: rtl/ctc_wave_timer.sv
module ctc_wave_timer
  import ctcw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       div_sel,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cmp_load,
  input  logic             pin_en,
  output logic             wave_o,
  output logic             match_o
);
  logic             run;
  logic             tick;
  logic             hit;
  logic [CNT_W-1:0] cnt;

  ctcw_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (div_sel),
    .run_o  (run),
    .tick_o (tick)
  );

  ctcw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .tick_i     (tick),
    .cmp_val_i  (cmp_val),
    .cmp_load_i (cmp_load),
    .cnt_o      (cnt),
    .hit_o      (hit)
  );

  ctcw_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .en_i    (pin_en),
    .wave_o  (wave_o),
    .match_o (match_o)
  );

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((div_sel == 3'd0 || div_sel > 3'd5) && !cmp_load)
      |=> ($stable(cnt) && $stable(wave_o) && !match_o)); // R2
endmodule

// File: tb/tb_ctc_wave_timer.sv
module tb_ctc_wave_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic [15:0] cmp_val = '0;
  logic        cmp_load = 1'b0;
  logic        pin_en = 1'b1;
  logic        wave_o;
  logic        match_o;
  int          nchk = 0;
  int          nfail = 0;
  int          cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctc_wave_timer dut (.*);

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] cmp;
    logic [31:0] half;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 16'd0,    32'd1},
    '{3'd1, 16'd5,    32'd6},
    '{3'd1, 16'd1,    32'd2},
    '{3'd2, 16'd3,    32'd32},
    '{3'd3, 16'd1,    32'd128},
    '{3'd4, 16'd0,    32'd256},
    '{3'd5, 16'd0,    32'd1024},
    '{3'd2, 16'd2272, 32'd18184}
  };

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; div_sel = 3'd0; cmp_load = 1'b0; pin_en = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Load a compare value while stopped (R5), then start with code sel.
  task automatic start(input logic [2:0] sel, input logic [15:0] c);
    cmp_val = c; cmp_load = 1'b1;
    @(negedge clk);
    cmp_load = 1'b0; div_sel = sel;
  endtask

  task automatic wait_toggle(output int n);
    logic prev;
    prev = wave_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (wave_o == prev && n < 40000);
  endtask

  initial begin
    int n;
    int m;
    logic w;
    // R8: reset state
    do_reset();
    check("R8 wave after reset", int'(wave_o), 0);
    check("R8 match after reset", int'(match_o), 0);

    // R1 / R3 / R5: vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      start(VEC[i].sel, VEC[i].cmp);
      wait_toggle(n);
      check($sformatf("R1 R5 first half vec %0d", i), n, int'(VEC[i].half));
      check($sformatf("R7 flag at toggle vec %0d", i), int'(match_o), 1);
      wait_toggle(n);
      check($sformatf("R3 second half vec %0d", i), n, int'(VEC[i].half));
    end

    // R4: lower the compare value in mid-count
    do_reset();
    start(3'd1, 16'd10);
    wait_toggle(n);
    check("R4 initial half", n, 11);
    cmp_val = 16'd2; cmp_load = 1'b1;
    @(negedge clk);
    cmp_load = 1'b0;
    wait_toggle(n);
    check("R4 old limit kept", n + 1, 11);
    wait_toggle(n);
    check("R4 new limit applied", n, 3);

    // R2: code 6 and code 0 freeze pin and flag
    div_sel = 3'd6;
    w = wave_o; m = 0;
    @(negedge clk);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (wave_o != w || match_o) m++;
    end
    check("R2 code 6 holds", m, 0);
    div_sel = 3'd0; m = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (wave_o != w || match_o) m++;
    end
    check("R2 code 0 holds", m, 0);

    // R6 / R7: pin disconnected, matches still reported
    do_reset();
    pin_en = 1'b0;
    start(3'd1, 16'd3);
    m = 0; n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (match_o) m++;
      if (wave_o) n++;
    end
    check("R7 pulses with pin off", m, 10);
    check("R6 pin held low", n, 0);
    pin_en = 1'b1;
    wait_toggle(n);
    check("R6 toggles when reconnected", int'(wave_o), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule